// File: doc/BRIEF.md
# Parallel Camera Pixel Output Formatter

This block turns pixels held in an upstream frame store into a parallel, camera-style video stream. On every cycle where the pixel enable is high, it drives a 16-bit data word, a line-valid strobe and a frame-valid strobe. It also drives a line number, a column-pair index and a frame tag, and the frame store answers these in the same cycle with two horizontally adjacent pixels. Each pixel word is 24 bits, laid out as luma in [7:0], blue chroma in [15:8] and red chroma in [23:16]. The raw 14-bit sample occupies bits [13:0] of the word.

The block samples all of its configuration at the start of each frame. This configuration covers the output mode, the component order, the chroma siting, the frame height, the line length and both idle intervals. A calibration request is also sampled only at that point. If the request is seen, the next frame is either sent with every output held inactive, or sent as a replay of the previous frame. Replay is chosen when zoom is on and the mode carries 8-bit components. The frame tag tells the frame store which picture to serve, and it does not advance during a replay.

Top module: `pvid_fmt`

## Requirements
- R1: While reset is asserted, vid_lv, vid_fv and vid_data are all zero, and on a clock edge where pix_en is low none of these outputs changes.
- R2: A frame has 256 lines when cfg_tall is 0 and 512 lines when it is 1. Each line shows vid_lv high for cfg_ppl enabled ticks, or for 2*cfg_ppl ticks in the double-rate mode. vid_fv is high from the first pixel of line 0 to the last pixel of the last line, and vid_lv is never high without vid_fv.
- R3: Between two lines there are exactly cfg_line_idle ticks with vid_fv high and vid_lv low. Between two frames there are exactly cfg_frame_idle ticks with vid_fv low. Both values are at least 1.
- R4: vid_data is zero on every tick where vid_lv is low. Data and both strobes change on the same enabled tick.
- R5: Mode code 0 sends the raw sample zero-extended as {2'b0, word[13:0]}. Mode codes 1 and 2 send {8'h00, word[7:0]}, and codes 5 to 7 behave like code 1.
- R6: Mode code 3 sends one pixel per tick as {chroma, luma}. The chroma is the blue value on even columns and the red value on odd columns.
- R7: Mode code 4 sends each pixel as two bytes on vid_data[7:0] over two ticks. With cfg_c_first at 0 the luma comes first, and with it at 1 the chroma comes first. The chroma follows the same even/odd rule as R6.
- R8: With cfg_centered at 0, the chroma of a column pair is taken from the even pixel. With it at 1, the chroma is floor((even + odd) / 2) for each chroma component.
- R9: A change to any configuration input in the middle of a frame has no effect until the next frame starts.
- R10: If cal_req is high at a frame start and the replay condition of R11 does not hold, that frame keeps its full timing but vid_lv, vid_fv and vid_data stay zero throughout, and fb_frame does not advance.
- R11: If cal_req and zoom_en are both high at a frame start and the mode code is not 0, the frame is sent again with the previous fb_frame value. Its data is therefore identical to the previous frame.
- R12: With mode code 0, zoom_en has no effect, so a calibration request still produces an inactive frame.
- R13: fb_frame is 0 for the first frame after reset and increases by one at each newly sent frame. fb_line and fb_pair address the pixels being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pix_en | input | 1 | Pixel tick enable |
| cfg_mode | input | 3 | Output mode code |
| cfg_c_first | input | 1 | Double-rate byte order: 1 = chroma first |
| cfg_centered | input | 1 | Chroma siting: 1 = averaged pair |
| cfg_tall | input | 1 | Frame height: 1 = 512 lines |
| cfg_ppl | input | PPL_W | Pixels per line (even) |
| cfg_line_idle | input | IDLE_W | Idle ticks between lines |
| cfg_frame_idle | input | IDLE_W | Idle ticks between frames |
| cal_req | input | 1 | Calibration request |
| zoom_en | input | 1 | Zoom mode: replay instead of blanking |
| fb_line | output | LINE_W | Frame store line address |
| fb_pair | output | PPL_W-1 | Frame store column-pair address |
| fb_frame | output | TAG_W | Frame store picture tag |
| fb_data | input | 48 | Odd pixel [47:24], even pixel [23:0] |
| vid_lv | output | 1 | Line valid |
| vid_fv | output | 1 | Frame valid |
| vid_data | output | 16 | Pixel data |

## Verification
Two of the block's functions can act on the same enabled tick: the frame boundary and the calibration request, which decides what kind of frame the boundary opens. Each of them can also coincide with a configuration change. The bench raises and drops the request and changes the mode partway through frames. It then judges each boundary from the port behaviour: the length of the inactive stretch before the next frame, and whether the data that follows matches the previous picture tag, the next tag, or nothing at all. A separate frame is run with a gated enable, to show that the strobes and data hold on the skipped edges.

// File: rtl/pvid_pkg.sv
package pvid_pkg;
  localparam int PIX_W = 24;

  typedef enum logic [2:0] {
    PM_RAW14  = 3'd0,
    PM_MONO8  = 3'd1,
    PM_BAYER8 = 3'd2,
    PM_YC16   = 3'd3,
    PM_YC8X2  = 3'd4
  } pmode_e;

  typedef enum logic [1:0] {FK_NEW, FK_REPLAY, FK_BLANK} fkind_e;
  typedef enum logic [1:0] {SQ_LAUNCH, SQ_ACTIVE, SQ_LGAP, SQ_FGAP} sqst_e;

  // Chroma for a column pair: even sample or rounded-down mean of both.
  function automatic logic [7:0] chroma_mix(input logic [7:0] ev, input logic [7:0] od,
                                             input logic centered);
    logic [8:0] sum;
    sum = {1'b0, ev} + {1'b0, od};
    return centered ? sum[8:1] : ev;
  endfunction

  // What the next frame will be, judged at the frame boundary.
  function automatic fkind_e pick_kind(input logic cal, input logic zoom, input logic [2:0] mode);
    if (!cal) return FK_NEW;
    if (zoom && (mode != PM_RAW14)) return FK_REPLAY;
    return FK_BLANK;
  endfunction
endpackage

// File: rtl/pvid_seq.sv
module pvid_seq
  import pvid_pkg::*;
#(
  parameter int PPL_W       = 11,
  parameter int IDLE_W      = 12,
  parameter int TAG_W       = 8,
  parameter int LINES_SHORT = 256,
  parameter int LINES_TALL  = 512,
  parameter int LINE_W      = $clog2(LINES_TALL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_c_first,
  input  logic              cfg_centered,
  input  logic              cfg_tall,
  input  logic [PPL_W-1:0]  cfg_ppl,
  input  logic [IDLE_W-1:0] cfg_line_idle,
  input  logic [IDLE_W-1:0] cfg_frame_idle,
  input  logic              cal_req,
  input  logic              zoom_en,
  output sqst_e             st,
  output fkind_e            kind_q,
  output logic [2:0]        mode_q,
  output logic              c_first_q,
  output logic              cent_q,
  output logic [LINE_W-1:0] line_q,
  output logic [PPL_W-1:0]  pix_idx,
  output logic              phase,
  output logic [TAG_W-1:0]  tag_q,
  output logic              frame_start
);
  logic              tall_q;
  logic [PPL_W-1:0]  ppl_q;
  logic [IDLE_W-1:0] lidle_q, fidle_q, cnt;
  logic [PPL_W:0]    tick, act_ticks;
  logic [TAG_W-1:0]  tag_next;
  logic              yc8_q;
  logic [IDLE_W-1:0] lidle_eff, fidle_eff;
  logic [LINE_W-1:0] last_line;
  fkind_e            kind_d;

  assign yc8_q     = (mode_q == PM_YC8X2);
  assign act_ticks = yc8_q ? {ppl_q, 1'b0} : {1'b0, ppl_q};
  assign lidle_eff = (lidle_q == '0) ? IDLE_W'(1) : lidle_q;
  assign fidle_eff = (fidle_q == '0) ? IDLE_W'(1) : fidle_q;
  assign last_line = tall_q ? LINE_W'(LINES_TALL - 1) : LINE_W'(LINES_SHORT - 1);
  assign kind_d    = pick_kind(cal_req, zoom_en, cfg_mode);
  assign pix_idx   = yc8_q ? tick[PPL_W:1] : tick[PPL_W-1:0];
  assign phase     = tick[0];

  assign frame_start = pix_en &&
                       ((st == SQ_LAUNCH) || ((st == SQ_FGAP) && (cnt == fidle_eff - IDLE_W'(1))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_LAUNCH;
      kind_q    <= FK_NEW;
      mode_q    <= PM_MONO8;
      c_first_q <= 1'b0;
      cent_q    <= 1'b0;
      tall_q    <= 1'b0;
      ppl_q     <= '0;
      lidle_q   <= '0;
      fidle_q   <= '0;
      cnt       <= '0;
      tick      <= '0;
      line_q    <= '0;
      tag_q     <= '0;
      tag_next  <= '0;
    end else if (pix_en) begin
      if (frame_start) begin
        st        <= SQ_ACTIVE;
        line_q    <= '0;
        tick      <= '0;
        kind_q    <= kind_d;
        mode_q    <= cfg_mode;
        c_first_q <= cfg_c_first;
        cent_q    <= cfg_centered;
        tall_q    <= cfg_tall;
        ppl_q     <= cfg_ppl;
        lidle_q   <= cfg_line_idle;
        fidle_q   <= cfg_frame_idle;
        if (kind_d == FK_NEW) begin
          tag_q    <= tag_next;
          tag_next <= tag_next + TAG_W'(1);
        end
      end else begin
        unique case (st)
          SQ_ACTIVE: begin
            if (tick == act_ticks - 1'b1) begin
              tick <= '0;
              cnt  <= '0;
              st   <= (line_q == last_line) ? SQ_FGAP : SQ_LGAP;
            end else begin
              tick <= tick + 1'b1;
            end
          end
          SQ_LGAP: begin
            if (cnt == lidle_eff - IDLE_W'(1)) begin
              st     <= SQ_ACTIVE;
              line_q <= line_q + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          SQ_FGAP: cnt <= cnt + 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R9
  frame_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(mode_q) && $stable(kind_q) && $stable(cent_q) && $stable(c_first_q)));

  // R11
  replay_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (kind_d == FK_REPLAY)) |=> $stable(tag_q));

  // R12
  raw_no_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == FK_REPLAY) |-> (mode_q != PM_RAW14));
endmodule

// File: rtl/pvid_pack.sv
module pvid_pack
  import pvid_pkg::*;
(
  input  logic [2*PIX_W-1:0] pair,
  input  logic [2:0]         mode,
  input  logic               c_first,
  input  logic               centered,
  input  logic               odd,
  input  logic               phase,
  output logic [15:0]        data
);
  logic [PIX_W-1:0] px;
  logic [7:0]       cb, cr, chroma, luma;

  assign px     = odd ? pair[2*PIX_W-1:PIX_W] : pair[PIX_W-1:0];
  assign luma   = px[7:0];
  assign cb     = chroma_mix(pair[15:8],  pair[PIX_W+15:PIX_W+8],  centered);
  assign cr     = chroma_mix(pair[23:16], pair[PIX_W+23:PIX_W+16], centered);
  assign chroma = odd ? cr : cb;

  always_comb begin
    unique case (mode)
      PM_RAW14: data = {2'b00, px[13:0]};
      PM_YC16:  data = {chroma, luma};
      PM_YC8X2: data = {8'h00, (phase ^ c_first) ? chroma : luma};
      default:  data = {8'h00, luma};
    endcase
  end
endmodule

// File: rtl/pvid_fmt.sv
module pvid_fmt
  import pvid_pkg::*;
#(
  parameter int PPL_W       = 11,
  parameter int IDLE_W      = 12,
  parameter int TAG_W       = 8,
  parameter int LINES_SHORT = 256,
  parameter int LINES_TALL  = 512,
  parameter int LINE_W      = $clog2(LINES_TALL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_c_first,
  input  logic              cfg_centered,
  input  logic              cfg_tall,
  input  logic [PPL_W-1:0]  cfg_ppl,
  input  logic [IDLE_W-1:0] cfg_line_idle,
  input  logic [IDLE_W-1:0] cfg_frame_idle,
  input  logic              cal_req,
  input  logic              zoom_en,
  output logic [LINE_W-1:0] fb_line,
  output logic [PPL_W-2:0]  fb_pair,
  output logic [TAG_W-1:0]  fb_frame,
  input  logic [47:0]       fb_data,
  output logic              vid_lv,
  output logic              vid_fv,
  output logic [15:0]       vid_data
);
  sqst_e            st;
  fkind_e           kind_q;
  logic [2:0]       mode_q;
  logic             c_first_q, cent_q, phase, frame_start;
  logic [PPL_W-1:0] pix_idx;
  logic [15:0]      packed_px;
  logic             blank_now, send_px, send_gap;

  pvid_seq #(
    .PPL_W(PPL_W), .IDLE_W(IDLE_W), .TAG_W(TAG_W),
    .LINES_SHORT(LINES_SHORT), .LINES_TALL(LINES_TALL), .LINE_W(LINE_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .cfg_mode(cfg_mode), .cfg_c_first(cfg_c_first), .cfg_centered(cfg_centered),
    .cfg_tall(cfg_tall), .cfg_ppl(cfg_ppl), .cfg_line_idle(cfg_line_idle),
    .cfg_frame_idle(cfg_frame_idle), .cal_req(cal_req), .zoom_en(zoom_en),
    .st(st), .kind_q(kind_q), .mode_q(mode_q), .c_first_q(c_first_q), .cent_q(cent_q),
    .line_q(fb_line), .pix_idx(pix_idx), .phase(phase), .tag_q(fb_frame),
    .frame_start(frame_start)
  );

  assign fb_pair = pix_idx[PPL_W-1:1];

  pvid_pack u_pack (
    .pair(fb_data), .mode(mode_q), .c_first(c_first_q), .centered(cent_q),
    .odd(pix_idx[0]), .phase(phase), .data(packed_px)
  );

  assign blank_now = (kind_q == FK_BLANK);
  assign send_px   = (st == SQ_ACTIVE) && !blank_now;
  assign send_gap  = (st == SQ_LGAP) && !blank_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_lv   <= 1'b0;
      vid_fv   <= 1'b0;
      vid_data <= '0;
    end else if (pix_en) begin
      vid_lv   <= send_px;
      vid_fv   <= send_px || send_gap;
      vid_data <= send_px ? packed_px : 16'h0000;
    end
  end

  // R2
  lv_in_fv_chk: assert property (@(posedge clk) disable iff (!rst_n) vid_lv |-> vid_fv);

  // R4
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_lv |-> (vid_data == 16'h0000));

  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable({vid_lv, vid_fv, vid_data}));

  // R3
  boundary_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !vid_fv);

  // R10
  blank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_now |-> (!vid_fv && !vid_lv));
endmodule

// File: tb/tb_pvid_fmt.sv
module tb_pvid_fmt;
  localparam int CLK_PERIOD = 10;
  localparam int FIDLE = 5;
  localparam int LIDLE = 3;
  localparam int PPL   = 8;
  localparam int LIMIT = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0;
  logic [2:0]  cfg_mode = 3'd1;
  logic        cfg_c_first = 1'b0, cfg_centered = 1'b0, cfg_tall = 1'b0;
  logic [10:0] cfg_ppl = 11'(PPL);
  logic [11:0] cfg_line_idle = 12'(LIDLE), cfg_frame_idle = 12'(FIDLE);
  logic        cal_req = 1'b0, zoom_en = 1'b0;
  logic [8:0]  fb_line;
  logic [9:0]  fb_pair;
  logic [7:0]  fb_frame;
  logic [47:0] fb_data;
  logic        vid_lv, vid_fv;
  logic [15:0] vid_data;

  int total = 0, bad = 0, cycles = 0, stab_bad = 0;
  bit gated = 0;
  logic [2:0] chg_mode;
  logic chg_cal, chg_zoom;

  always #(CLK_PERIOD/2) clk = ~clk;

  pvid_fmt dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .cfg_mode(cfg_mode),
    .cfg_c_first(cfg_c_first), .cfg_centered(cfg_centered), .cfg_tall(cfg_tall),
    .cfg_ppl(cfg_ppl), .cfg_line_idle(cfg_line_idle), .cfg_frame_idle(cfg_frame_idle),
    .cal_req(cal_req), .zoom_en(zoom_en), .fb_line(fb_line), .fb_pair(fb_pair),
    .fb_frame(fb_frame), .fb_data(fb_data), .vid_lv(vid_lv), .vid_fv(vid_fv),
    .vid_data(vid_data)
  );

  function automatic logic [23:0] gen(input int t, input int l, input int c);
    logic [7:0] y, cb, cr;
    y  = 8'((l * 7 + c * 3 + t * 11) % 256);
    cb = 8'((c * 5 + t * 13 + l) % 256);
    cr = 8'(((l * 3) ^ (c * 9) ^ (t * 29)) % 256);
    return {cr, cb, y};
  endfunction

  // Frame store model: answers the addressed column pair in the same cycle (R13).
  always_comb fb_data = {gen(int'(fb_frame), int'(fb_line), 2 * int'(fb_pair) + 1),
                         gen(int'(fb_frame), int'(fb_line), 2 * int'(fb_pair))};

  function automatic logic [15:0] exp_data(input int md, input int cf, input int cen,
                                           input int tg, input int ln, input int k);
    int p, ph, c, r;
    logic [23:0] pe, po, px;
    logic [7:0] ch;
    p  = (md == 4) ? k / 2 : k;
    ph = k % 2;
    pe = gen(tg, ln, p - (p % 2));
    po = gen(tg, ln, p - (p % 2) + 1);
    px = (p % 2 == 1) ? po : pe;
    c  = cen ? (int'(pe[15:8]) + int'(po[15:8])) / 2 : int'(pe[15:8]);
    r  = cen ? (int'(pe[23:16]) + int'(po[23:16])) / 2 : int'(pe[23:16]);
    ch = (p % 2 == 1) ? 8'(r) : 8'(c);
    case (md)
      0: return {2'b00, px[13:0]};
      3: return {ch, px[7:0]};
      4: return {8'h00, ((ph == 0) == (cf == 0)) ? px[7:0] : ch};
      default: return {8'h00, px[7:0]};
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // One enabled tick; outputs are read at the following falling edge.
  task automatic adv();
    bit took;
    logic [17:0] snap;
    took = 0;
    while (!took) begin
      snap = {vid_lv, vid_fv, vid_data};
      @(posedge clk);
      took = pix_en;
      @(negedge clk);
      if (!took && (snap !== {vid_lv, vid_fv, vid_data})) stab_bad++;
      pix_en = gated ? ~pix_en : 1'b1;
    end
  endtask

  task automatic wait_quiet(input int n, input string rq);
    int loud = 0;
    for (int i = 0; i < n; i++) begin
      adv();
      if (vid_fv || vid_lv || vid_data != 0) loud++;
    end
    chk(loud == 0, rq, "outputs during inactive frame", loud, 0);
  endtask

  task automatic grab(input int md, input int cf, input int cen, input int tall, input int tg,
                      input int exp_gap, input string rq_gap, input int chg_line, input string rq);
    int nl, a, gap, dbad, tbad, zbad, fa, fe;
    logic [15:0] ex;
    nl = tall ? 512 : 256;
    a  = (md == 4) ? 2 * PPL : PPL;
    gap = 0; dbad = 0; tbad = 0; zbad = 0; fa = 0; fe = 0;
    adv();
    while (!vid_fv && gap < 20000) begin
      gap++;
      adv();
    end
    if (exp_gap >= 0) chk(gap == exp_gap, rq_gap, "ticks with fv low before frame", gap, exp_gap);
    for (int ln = 0; ln < nl; ln++) begin
      if (ln == chg_line) begin
        cfg_mode = chg_mode; cal_req = chg_cal; zoom_en = chg_zoom;
      end
      for (int k = 0; k < a; k++) begin
        if (ln != 0 || k != 0) adv();
        ex = exp_data(md, cf, cen, tg, ln, k);
        if (!(vid_lv && vid_fv)) tbad++;
        if (vid_data !== ex) begin
          if (dbad == 0) begin fa = int'(vid_data); fe = int'(ex); end
          dbad++;
        end
      end
      if (ln < nl - 1) begin
        for (int j = 0; j < LIDLE; j++) begin
          adv();
          if (!(vid_fv && !vid_lv)) tbad++;
          if (vid_data !== 16'h0000) zbad++;
        end
      end
    end
    adv();
    if (vid_fv || vid_lv) tbad++;
    if (vid_data !== 16'h0000) zbad++;
    // Data depends on the tag and addresses the design sends to the frame store (R13).
    chk(dbad == 0, rq, "pixel data first mismatch", fa, fe);
    chk(tbad == 0, "R2", "line/frame strobe pattern errors (R3 line idle)", tbad, 0);
    chk(zbad == 0, "R4", "nonzero data with lv low", zbad, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > LIMIT) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, LIMIT);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int blank_gap;
    chg_mode = 3'd1; chg_cal = 0; chg_zoom = 0;
    blank_gap = 2 * FIDLE + (256 * PPL + 255 * LIDLE) - 21;
    repeat (4) @(negedge clk);
    chk(!vid_lv && !vid_fv && vid_data == 0, "R1", "outputs under reset",
        int'({vid_lv, vid_fv, vid_data}), 0);
    rst_n = 1'b1;
    pix_en = 1'b1;

    grab(1, 0, 0, 0, 0, -1, "R3", -1, "R5 mono8");
    cfg_mode = 3'd0; cfg_tall = 1'b1;
    grab(0, 0, 0, 1, 1, FIDLE - 1, "R3", -1, "R5 raw14 tall");
    cfg_mode = 3'd3; cfg_tall = 1'b0;
    grab(3, 0, 0, 0, 2, FIDLE - 1, "R3", -1, "R6 yc16 cosited");
    cfg_centered = 1'b1;
    grab(3, 0, 1, 0, 3, FIDLE - 1, "R3", -1, "R8 yc16 centered");
    cfg_mode = 3'd4; cfg_centered = 1'b0;
    grab(4, 0, 0, 0, 4, FIDLE - 1, "R3", -1, "R7 yc8 luma first");
    cfg_c_first = 1'b1; cfg_centered = 1'b1;
    grab(4, 1, 1, 0, 5, FIDLE - 1, "R3", -1, "R7 yc8 chroma first centered (R8)");
    cfg_mode = 3'd2; cfg_c_first = 1'b0; cfg_centered = 1'b0;
    chg_mode = 3'd0; chg_cal = 0; chg_zoom = 0;
    grab(2, 0, 0, 0, 6, FIDLE - 1, "R3", 100, "R9 mid-frame mode change ignored");
    chg_mode = 3'd0; chg_cal = 1; chg_zoom = 0;
    grab(0, 0, 0, 0, 7, FIDLE - 1, "R3", 10, "R5 raw14");
    wait_quiet(20, "R10");
    cal_req = 1'b0;
    chg_mode = 3'd0; chg_cal = 1; chg_zoom = 1;
    grab(0, 0, 0, 0, 8, blank_gap, "R10", 10, "R10 tag held over blank");
    wait_quiet(20, "R12");
    cal_req = 1'b0; cfg_mode = 3'd1;
    chg_mode = 3'd1; chg_cal = 1; chg_zoom = 1;
    grab(1, 0, 0, 0, 9, blank_gap, "R12", 100, "R13 mono8 after raw blank");
    chg_mode = 3'd1; chg_cal = 0; chg_zoom = 1;
    grab(1, 0, 0, 0, 9, FIDLE - 1, "R3", 100, "R11 zoom replay of previous frame");
    grab(1, 0, 0, 0, 10, FIDLE - 1, "R3", -1, "R13 tag resumes after replay");
    gated = 1;
    stab_bad = 0;
    grab(1, 0, 0, 0, 11, FIDLE - 1, "R3", -1, "R5 mono8 gated enable");
    chk(stab_bad == 0, "R1", "output change on disabled edge", stab_bad, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule